// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one channel of a multi-channel event timer. It stores the channel's control word, a comparator and a period. Each cycle it compares the comparator against a shared free-running main counter that is supplied from outside. When the counter reaches the comparator, and both the global enable and the channel enable are set, the block emits a single-cycle edge interrupt. The interrupt is tagged with a 5-bit interrupt number.

In one-shot mode the channel fires once and then waits until its comparator is rewritten. In periodic mode the comparator moves forward by whole periods after each expiry, and the advanced value can be read back. A writable 32-bit mode narrows the comparator and the period and compares only the low half of the counter. A set-value flag lets software load the comparator of a periodic channel without touching its period. A global legacy-routing input overrides the interrupt number for the first two channels.

The surrounding timer instantiates one copy per channel with a distinct `CHAN_ID`. It decodes register writes into the strobes below and reads back the control word and the comparator.

Top module: `tmr_channel`

## Requirements
- R1: After reset the control readback is 0x00F00000_00000030 and the comparator reads all ones. `irq_pulse` is 0 and `irq_num` is 0.
- R2: A control write changes only bit 1 (level select, which is stored but not acted upon), bit 2 (channel enable), bit 3 (periodic), bit 6 (set-value), bit 8 (32-bit mode) and bits 13:9 (route). This is writable mask 0x3F4E. Bits 4 and 5 always read 1. The upper readback word is the route-capability mask 0x00F00000, which permits IRQ 20 to 23.
- R3: `irq_pulse` is high for exactly one cycle, on the clock edge after a cycle in which `glb_en` was 1, control bit 2 was 1, the comparator was due and the channel was armed. It never fires while `glb_en` is 0.
- R4: After firing, a one-shot channel stays silent until one of three things happens: its comparator is written, a restart event occurs, or the counter falls behind the comparator and reaches it again.
- R5: A comparator write with bit 6 clear, on a periodic channel (bit 3 set), loads both the comparator and the period with the same value. That value is the written value raised to at least `MIN_TICKS` (6250). Its top bit is then cleared: bit 31 in 32-bit mode, bit 63 otherwise.
- R6: A comparator write with bit 6 set loads only the comparator, without clamping, and leaves the period unchanged. Bit 6 then reads 0.
- R7: On each expiry of a periodic channel the comparator advances by the period, one period per cycle, until it lies ahead of the counter. The readback shows the advanced value. No extra pulse is raised while the comparator catches up.
- R8: In 32-bit mode (bit 8) the comparator, the period and written comparator values are truncated to 32 bits, and only the low 32 counter bits take part in the comparison. A control write that sets bit 8 truncates the stored comparator and period at once.
- R9: In 64-bit mode the comparator is due when (counter − comparator), read as a signed value, is non-negative, so a comparator set in the past fires immediately. In 32-bit mode it is due when the 32-bit difference is at most `LATE_WIN` (61035). A comparator further in the past waits until the low counter half wraps around to it.
- R10: `irq_num` is registered. With `glb_legacy` set, channel 0 reports 0 and channel 1 reports 8. Otherwise `irq_num` is the route field in bits 13:9.
- R11: The channel is re-armed by a rising `glb_en`. It is also re-armed by a control write made while `glb_en` is 1 that leaves the channel enabled and changes bit 3, sets bit 8 from 0, or sets bit 2 from 0. Rewriting the same control value has no effect on the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_cnt | input | CNT_W | Shared main counter value |
| glb_en | input | 1 | Global counter and interrupt enable |
| glb_legacy | input | 1 | Global legacy routing select |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cmp_we | input | 1 | Comparator write strobe |
| cmp_wdata | input | CNT_W | Comparator write data |
| cfg_rdata | output | 64 | Route-capability mask and control word |
| cmp_rdata | output | CNT_W | Current (advanced) comparator |
| irq_pulse | output | 1 | Single-cycle edge interrupt |
| irq_num | output | 5 | Interrupt number of this channel |

## Verification
The bench builds the channel with `CHAN_ID` = 1 and the default widths, clamp floor and late window. This makes the legacy override to IRQ 8 reachable alongside the plain route field. The main counter is a bench-driven input, so the clamp floor of 6250 and the 61035-tick late window of the 32-bit mode are reached by placing the counter directly at chosen values rather than by waiting for it to count. The same setup reaches the 32-bit wrap and the 64-bit top-bit clearing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CB_LEVEL  = 1;
  localparam int CB_EN     = 2;
  localparam int CB_PER    = 3;
  localparam int CB_PCAP   = 4;
  localparam int CB_WCAP   = 5;
  localparam int CB_SETV   = 6;
  localparam int CB_M32    = 8;
  localparam int CB_RT_LSB = 9;
  localparam int RT_W      = 5;

  localparam logic [31:0] CFG_WMASK = (32'd1 << CB_LEVEL) | (32'd1 << CB_EN) |
                                      (32'd1 << CB_PER) | (32'd1 << CB_SETV) |
                                      (32'd1 << CB_M32) |
                                      (((32'd1 << RT_W) - 32'd1) << CB_RT_LSB);
  localparam logic [31:0] CFG_RESET = (32'd1 << CB_PCAP) | (32'd1 << CB_WCAP);

  typedef struct packed {
    logic            en;
    logic            per;
    logic            setv;
    logic            m32;
    logic [RT_W-1:0] route;
  } chan_ctl_t;
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        glb_en,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        clr_setval,
  output logic [31:0] cfg_word,
  output chan_ctl_t   ctl,
  output logic        restart_cfg,
  output logic        trunc_req
);
  logic [31:0] cfg_q;
  logic [31:0] cfg_next;

  assign cfg_next = (cfg_q & ~CFG_WMASK) | (cfg_wdata & CFG_WMASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
    end else begin
      if (cfg_we)     cfg_q <= cfg_next;
      if (clr_setval) cfg_q[CB_SETV] <= 1'b0;
    end
  end

  // re-evaluate expiry when an enabled channel changes mode or width
  assign restart_cfg = cfg_we && glb_en && cfg_next[CB_EN] &&
                       ((cfg_next[CB_PER] ^ cfg_q[CB_PER]) ||
                        (cfg_next[CB_M32] && !cfg_q[CB_M32]) ||
                        !cfg_q[CB_EN]);
  assign trunc_req   = cfg_we && cfg_wdata[CB_M32];

  assign cfg_word  = cfg_q;
  assign ctl.en    = cfg_q[CB_EN];
  assign ctl.per   = cfg_q[CB_PER];
  assign ctl.setv  = cfg_q[CB_SETV];
  assign ctl.m32   = cfg_q[CB_M32];
  assign ctl.route = cfg_q[CB_RT_LSB +: RT_W];

  AST_RO_BITS: assert property (@(posedge clk) disable iff (rst)
    (cfg_q & ~CFG_WMASK) == CFG_RESET); // R2
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
  parameter int CNT_W     = 64,
  parameter int NARROW_W  = 32,
  parameter int MIN_TICKS = 6250,
  parameter int LATE_WIN  = 61035
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] main_cnt,
  input  logic             eff_en,
  input  logic             mode32,
  input  logic             periodic,
  input  logic             setval,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             trunc_req,
  input  logic             restart,
  output logic [CNT_W-1:0] cmp_q,
  output logic             fire,
  output logic             clr_setval
);
  localparam logic [CNT_W-1:0] NMASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [CNT_W-1:0] TOP_W = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] TOP_N = {{(CNT_W-NARROW_W){1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]    MIN_V  = CNT_W'(MIN_TICKS);
  localparam logic [NARROW_W-1:0] LATE_V = NARROW_W'(LATE_WIN);

  logic [CNT_W-1:0] prd_q, cmp_n, prd_n;
  logic [CNT_W-1:0] wval, floor_v, prd_v, elapsed;
  logic             armed_q, armed_n, due, advance;

  assign wval    = mode32 ? (cmp_wdata & NMASK) : cmp_wdata;
  assign floor_v = (wval < MIN_V) ? MIN_V : wval;
  assign prd_v   = floor_v & ~(mode32 ? TOP_N : TOP_W);

  assign elapsed = main_cnt - cmp_q;
  assign due     = mode32 ? (elapsed[NARROW_W-1:0] <= LATE_V) : !elapsed[CNT_W-1];
  assign fire    = eff_en && due && armed_q;
  assign advance = eff_en && periodic && due && (prd_q != '0);
  assign clr_setval = cmp_we && setval;

  always_comb begin
    cmp_n = cmp_q;
    prd_n = prd_q;
    if (cmp_we) begin
      if (setval) begin
        cmp_n = wval;
      end else if (periodic) begin
        cmp_n = prd_v;
        prd_n = prd_v;
      end else begin
        cmp_n = wval;
      end
    end else if (advance) begin
      cmp_n = cmp_q + prd_q;
    end
    if (mode32 || trunc_req) begin
      cmp_n = cmp_n & NMASK;
      prd_n = prd_n & NMASK;
    end
  end

  always_comb begin
    if (cmp_we)                armed_n = 1'b1;
    else if (fire)             armed_n = 1'b0;
    else if (restart || !due)  armed_n = 1'b1;
    else                       armed_n = armed_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= '1;
      prd_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      cmp_q   <= cmp_n;
      prd_q   <= prd_n;
      armed_q <= armed_n;
    end
  end

  AST_ONE_FIRE: assert property (@(posedge clk) disable iff (rst)
    fire && !cmp_we |=> !fire); // R4
  AST_SETVAL_PERIOD: assert property (@(posedge clk) disable iff (rst)
    cmp_we && setval && !trunc_req |=> $stable(prd_q)); // R6
  AST_WIDE_TOP: assert property (@(posedge clk) disable iff (rst)
    cmp_we && !setval && periodic && !mode32 && !trunc_req |=> !prd_q[CNT_W-1]); // R5
  AST_NARROW_HI: assert property (@(posedge clk) disable iff (rst)
    mode32 |-> ((cmp_q | prd_q) & ~NMASK) == '0); // R8
endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out
  import tmr_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic            legacy,
  input  logic [RT_W-1:0] route,
  output logic            irq_pulse,
  output logic [RT_W-1:0] irq_num
);
  localparam logic            HAS_LEG = (CHAN_ID < 2);
  localparam logic [RT_W-1:0] LEG_NUM = (CHAN_ID == 0) ? RT_W'(0) : RT_W'(8);

  logic [RT_W-1:0] num_sel;
  assign num_sel = (HAS_LEG && legacy) ? LEG_NUM : route;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse <= 1'b0;
      irq_num   <= '0;
    end else begin
      irq_pulse <= fire;
      irq_num   <= num_sel;
    end
  end

  generate
    if (HAS_LEG) begin : g_leg
      AST_LEGACY_NUM: assert property (@(posedge clk) disable iff (rst)
        legacy |=> irq_num == LEG_NUM); // R10
    end else begin : g_route
      AST_ROUTE_NUM: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_num == $past(route)); // R10
    end
  endgenerate
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int          CNT_W     = 64,
  parameter int          NARROW_W  = 32,
  parameter int          CHAN_ID   = 0,
  parameter int          MIN_TICKS = 6250,
  parameter int          LATE_WIN  = 61035,
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] main_cnt,
  input  logic             glb_en,
  input  logic             glb_legacy,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [63:0]      cfg_rdata,
  output logic [CNT_W-1:0] cmp_rdata,
  output logic             irq_pulse,
  output logic [RT_W-1:0]  irq_num
);
  logic [31:0] cfg_word;
  chan_ctl_t   ctl;
  logic        restart_cfg, trunc_req, clr_setval, fire;
  logic        glb_en_q, restart, eff_en;

  always_ff @(posedge clk) begin
    if (rst) glb_en_q <= 1'b0;
    else     glb_en_q <= glb_en;
  end

  assign eff_en  = glb_en && ctl.en;
  assign restart = restart_cfg || (glb_en && !glb_en_q);

  tmr_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .glb_en(glb_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .clr_setval(clr_setval), .cfg_word(cfg_word), .ctl(ctl),
    .restart_cfg(restart_cfg), .trunc_req(trunc_req)
  );

  tmr_cmp_unit #(
    .CNT_W(CNT_W), .NARROW_W(NARROW_W), .MIN_TICKS(MIN_TICKS), .LATE_WIN(LATE_WIN)
  ) u_cmp (
    .clk(clk), .rst(rst), .main_cnt(main_cnt), .eff_en(eff_en), .mode32(ctl.m32),
    .periodic(ctl.per), .setval(ctl.setv), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .trunc_req(trunc_req), .restart(restart), .cmp_q(cmp_rdata), .fire(fire),
    .clr_setval(clr_setval)
  );

  tmr_irq_out #(.CHAN_ID(CHAN_ID)) u_out (
    .clk(clk), .rst(rst), .fire(fire), .legacy(glb_legacy), .route(ctl.route),
    .irq_pulse(irq_pulse), .irq_num(irq_num)
  );

  assign cfg_rdata = {ROUTE_CAP, cfg_word};

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(glb_en)); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_pulse && !$past(cmp_we) |=> !irq_pulse); // R3
endmodule

// File: tb/tmr_channel_bench.sv
`timescale 1ns/1ps
module tmr_channel_bench;
  localparam logic [31:0] W_EN = 32'h4, W_PER = 32'h8, W_SETV = 32'h40, W_M32 = 32'h100;

  typedef struct packed {
    logic        m32;
    logic [63:0] wval;
    logic [63:0] exp_c;
  } vec_t;

  // plain periodic comparator writes: clamp, truncation, top-bit clearing (R5, R8)
  localparam vec_t VEC [0:6] = '{
    '{1'b0, 64'd100,                 64'd6250},
    '{1'b0, 64'd10000,               64'd10000},
    '{1'b1, 64'h1_0000_2000,         64'h2000},
    '{1'b1, 64'h8000_3000,           64'h3000},
    '{1'b0, 64'h8000_0000_0000_4000, 64'h4000},
    '{1'b0, 64'd6249,                64'd6250},
    '{1'b1, 64'd5,                   64'd6250}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] main_cnt = '0;
  logic        glb_en = 1'b0, glb_legacy = 1'b0;
  logic        cfg_we = 1'b0, cmp_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [63:0] cmp_wdata = '0;
  logic [63:0] cfg_rdata, cmp_rdata;
  logic        irq_pulse;
  logic [4:0]  irq_num;
  int          n_chk = 0, n_err = 0;
  logic [31:0] near32, far32;

  always #4 clk = ~clk;

  tmr_channel #(.CHAN_ID(1)) u_tmr_channel (
    .clk(clk), .rst(rst), .main_cnt(main_cnt), .glb_en(glb_en), .glb_legacy(glb_legacy),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .cfg_rdata(cfg_rdata), .cmp_rdata(cmp_rdata), .irq_pulse(irq_pulse), .irq_num(irq_num)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; glb_en = 1'b0; glb_legacy = 1'b0; main_cnt = '0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v; step(); cfg_we = 1'b0;
  endtask

  task automatic wr_cmp(input logic [63:0] v);
    cmp_we = 1'b1; cmp_wdata = v; step(); cmp_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1 cfg", cfg_rdata, 64'h00F0_0000_0000_0030);
    chk("R1 cmp", cmp_rdata, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1 pulse", {63'd0, irq_pulse}, 64'd0);
    chk("R1 num", {59'd0, irq_num}, 64'd0);
    rst = 1'b0; step();

    // R2 writable mask
    wr_cfg(32'hFFFF_FFFF);
    chk("R2 all ones", cfg_rdata, 64'h00F0_0000_0000_3F7E);
    wr_cfg(32'h0);
    chk("R2 all zeros", cfg_rdata, 64'h00F0_0000_0000_0030);

    // table: plain periodic writes then first expiry (R5 R7 R8)
    for (int i = 0; i < 7; i++) begin
      do_reset();
      wr_cfg(W_EN | W_PER | (VEC[i].m32 ? W_M32 : 32'h0));
      wr_cmp(VEC[i].wval);
      chk("R5 loaded comparator", cmp_rdata, VEC[i].exp_c);
      main_cnt = VEC[i].exp_c - 64'd1; glb_en = 1'b1; step();
      chk("R3 no pulse before match", {63'd0, irq_pulse}, 64'd0);
      main_cnt = VEC[i].exp_c; step();
      chk("R3 pulse at match", {63'd0, irq_pulse}, 64'd1);
      chk("R7 advanced by period", cmp_rdata, VEC[i].exp_c * 2);
      step();
      chk("R7 no pulse after advance", {63'd0, irq_pulse}, 64'd0);
    end

    // R6 set-value write keeps the period
    do_reset();
    wr_cfg(W_EN | W_PER);
    wr_cmp(64'd10000);
    wr_cfg(W_EN | W_PER | W_SETV);
    chk("R6 flag set", {63'd0, cfg_rdata[6]}, 64'd1);
    wr_cmp(64'd50);
    chk("R6 comparator unclamped", cmp_rdata, 64'd50);
    chk("R6 flag cleared", {63'd0, cfg_rdata[6]}, 64'd0);
    main_cnt = 64'd50; glb_en = 1'b1; step();
    chk("R6 pulse", {63'd0, irq_pulse}, 64'd1);
    chk("R6 period kept", cmp_rdata, 64'd10050);

    // R4 one-shot
    do_reset();
    glb_en = 1'b1;
    wr_cmp(64'd1000);
    wr_cfg(W_EN);
    main_cnt = 64'd999; step();
    chk("R4 before", {63'd0, irq_pulse}, 64'd0);
    main_cnt = 64'd1000; step();
    chk("R4 fires", {63'd0, irq_pulse}, 64'd1);
    main_cnt = 64'd1001; step();
    chk("R4 single", {63'd0, irq_pulse}, 64'd0);
    main_cnt = 64'd1500; step();
    chk("R4 stays silent", {63'd0, irq_pulse}, 64'd0);
    chk("R4 no advance", cmp_rdata, 64'd1000);

    // R11 restart rules
    wr_cfg(W_EN); step();
    chk("R11 same value no effect", {63'd0, irq_pulse}, 64'd0);
    wr_cfg(W_EN | W_PER); step();
    chk("R11 mode change rearms", {63'd0, irq_pulse}, 64'd1);
    wr_cfg(W_EN); step();
    chk("R11 mode back rearms", {63'd0, irq_pulse}, 64'd1);
    step();
    chk("R11 then silent", {63'd0, irq_pulse}, 64'd0);

    // R4 / R9 comparator rewrite at and behind the counter
    wr_cmp(64'd1500); step();
    chk("R4 rewrite fires", {63'd0, irq_pulse}, 64'd1);
    wr_cmp(64'd100); step();
    chk("R9 past fires now", {63'd0, irq_pulse}, 64'd1);

    // R3 global enable gate
    glb_en = 1'b0;
    wr_cmp(64'd200); step();
    chk("R3 gated off", {63'd0, irq_pulse}, 64'd0);
    glb_en = 1'b1; step();
    chk("R3 fires when enabled", {63'd0, irq_pulse}, 64'd1);

    // R8 / R9 32-bit mode
    do_reset();
    main_cnt = 64'h1_0000_1000;
    wr_cfg(W_EN | W_M32);
    chk("R8 truncated on mode set", cmp_rdata, 64'hFFFF_FFFF);
    wr_cmp(64'hABCD_0000_0000_0FFF);
    chk("R8 written value truncated", cmp_rdata, 64'h0FFF);
    glb_en = 1'b1; step();
    chk("R8 low half compared", {63'd0, irq_pulse}, 64'd1);
    near32 = 32'h1000 - 32'd60000;
    far32  = 32'h1000 - 32'd70000;
    wr_cmp({32'h0, near32}); step();
    chk("R9 inside window fires", {63'd0, irq_pulse}, 64'd1);
    wr_cmp({32'h0, far32}); step();
    chk("R9 beyond window waits", {63'd0, irq_pulse}, 64'd0);
    step();
    chk("R9 still waiting", {63'd0, irq_pulse}, 64'd0);
    main_cnt = {32'h2, far32}; step();
    chk("R9 fires after wrap", {63'd0, irq_pulse}, 64'd1);

    // R10 interrupt number
    do_reset();
    wr_cfg(32'd21 << 9); step();
    chk("R10 route field", {59'd0, irq_num}, 64'd21);
    glb_legacy = 1'b1; step();
    chk("R10 legacy override", {59'd0, irq_num}, 64'd8);
    glb_legacy = 1'b0; step();
    chk("R10 route restored", {59'd0, irq_num}, 64'd21);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule